// File: doc/BRIEF.md
# CKE Low-Power State Sequencer

This block sits on the controller side of a mobile DRAM channel. It moves the clock-enable pin into and out of three low-power states: power-down, self-refresh and deep power-down. A host state machine asks to enter a state through a valid/ready handshake and gives the kind of state it wants. It asks to leave the state through a second valid/ready handshake. The block drives CKE and a flag, `cmd_ok`, that tells the command scheduler when a command may go out on the bus.

Every minimum time is a parameter in picoseconds, together with a floor in clock cycles. Each time is converted at elaboration to the larger of two values: the rounded-up cycle count and the floor. Back-pressure is the only way the block holds a request off. `ent_ready` stays low while a residency or exit lockout is still counting, and while a reinitialization is still owed. `ext_ready` stays low until the current low state has lasted its minimum. The host must keep `valid` and its payload steady until `ready` is high. The transfer happens on the clock edge where both are high, so no request is ever lost.

Leaving deep power-down does not reopen the bus. The block raises `need_reinit` and keeps it high until the host pulses `reinit_ack`. Refresh timing belongs to a separate scheduler, so this block only reports when self-refresh is in progress.

Top module: `lp_cke_seq`

## Requirements
- R1: After reset, `cke`=1, `cmd_ok`=1, `lp_mode`=0, `sr_on`=0, `need_reinit`=0 and `sr_span`=00.
- R2: An entry is accepted on an edge where `ent_valid` and `ent_ready` are both high. `ent_kind` is encoded as 0 power-down, 1 self-refresh, 2 deep power-down and 3 no-op. A no-op is consumed without changing any output. For the other kinds, `cke` is 0 from the next cycle on. `cmd_ok` is never high while `cke` is 0.
- R3: `lp_mode` is encoded as 0 active, 1 idle power-down, 2 active power-down, 3 self-refresh and 4 deep power-down. A power-down is labelled 2 when any bit of `bank_open` is set at acceptance, and 1 otherwise.
- R4: With the exit request held from the start, `cke` stays low for exactly RES cycles. For power-down, RES = CKE_MIN_CYC. For self-refresh, RES = max(ceil(SR_MIN_PS/TCK_PS), SR_MIN_CYC, CKE_MIN_CYC). For deep power-down, RES = max(ceil(DPD_MIN_PS/TCK_PS), CKE_MIN_CYC). `ext_ready` is low until RES has elapsed.
- R5: Every high or low pulse of `cke` lasts at least CKE_MIN_CYC cycles. After CKE rises, `ent_ready` stays low for max(CKE_MIN_CYC-1, LOCK) cycles, where LOCK is the exit lockout.
- R6: After CKE rises, `cmd_ok` stays low for LOCK cycles. After power-down or deep power-down, LOCK = max(ceil(XP_PS/TCK_PS), XP_CYC). After self-refresh, LOCK = max(ceil(XSR_PS/TCK_PS), XSR_CYC).
- R7: `sr_span` takes `sr_span_in` when a self-refresh entry is accepted, and keeps that value until the next such entry. Later changes to `sr_span_in` have no effect. The encoding is 00 full array, 01 half, 10 quarter and 11 eighth.
- R8: Leaving deep power-down sets `need_reinit`. While it is set, `cmd_ok` and `ent_ready` stay low. A `reinit_ack` pulse clears it on the next edge.
- R9: An exit request while `cke` is high is ignored (`ext_ready`=0). An entry held during a lockout is taken at the first cycle it is allowed, so after a self-refresh exit CKE stays high for max(CKE_MIN_CYC, LOCK+1) cycles.
- R10: `sr_on` is high exactly while the block is in self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | 1 | Entry request valid |
| ent_ready | output | 1 | Entry may be taken this cycle |
| ent_kind | input | 2 | Requested state (0 PD, 1 SR, 2 DPD, 3 no-op) |
| sr_span_in | input | 2 | Array coverage for the next self-refresh |
| bank_open | input | NB | One bit per bank, set when the bank has a row open |
| ext_valid | input | 1 | Exit request valid |
| ext_ready | output | 1 | Exit may be taken this cycle |
| reinit_ack | input | 1 | Host has reinitialized the device after deep power-down |
| cke | output | 1 | Clock enable to the DRAM |
| cmd_ok | output | 1 | A command may issue this cycle |
| lp_mode | output | 3 | Current state code |
| sr_on | output | 1 | Self-refresh in progress |
| sr_span | output | 2 | Array coverage latched at self-refresh entry |
| need_reinit | output | 1 | Reinitialization owed after deep power-down |

## Verification
The bench sweeps every `bank_open` value for power-down and every span code for self-refresh, and it also covers deep power-down. Its configuration is chosen so that in one case the nanosecond value sets the residency and in another the cycle floor sets the lockout. A design that took only one of the two values would produce a visibly shorter CKE-low time or `cmd_ok` gap. An entry held through a long self-refresh lockout catches a design that drops the request or enters early. Changing the span input while self-refresh is active catches a latch that follows the input instead of holding. A no-op entry, an exit request while CKE is high, and the deep power-down reinitialization lock each show, at the ports, a design that changes state when it must not.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    LP_ON      = 3'd0,
    LP_PD_IDLE = 3'd1,
    LP_PD_ACT  = 3'd2,
    LP_SR      = 3'd3,
    LP_DPD     = 3'd4
  } lp_mode_e;

  typedef enum logic [1:0] {
    K_PD  = 2'd0,
    K_SR  = 2'd1,
    K_DPD = 2'd2,
    K_NOP = 2'd3
  } lp_kind_e;

  // Cycles needed to cover a time in ps, never below a cycle floor.
  function automatic int unsigned span_cycles(input int unsigned t_ps,
                                              input int unsigned tck_ps,
                                              input int unsigned floor_c);
    int unsigned c;
    c = (t_ps + tck_ps - 1) / tck_ps;
    return (c > floor_c) ? c : floor_c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lp_cnt.sv
module lp_cnt #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= W'(RST_VAL);
    else if (load)         cnt <= ld_val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lp_res_pick.sv
module lp_res_pick
  import lp_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned CKE_MIN = 3,
  parameter int unsigned RES_SR  = 3,
  parameter int unsigned RES_DPD = 3,
  parameter int unsigned LOCK_XP = 2,
  parameter int unsigned LOCK_SR = 2
) (
  input  logic           leaving,
  input  lp_kind_e       kind,
  input  lp_mode_e       cur_mode,
  output logic [W-1:0]   res_ld,
  output logic [W-1:0]   lock_ld
);
  // Residency counter is loaded with the count minus one: the move
  // itself takes the last cycle.
  always_comb begin
    if (leaving) begin
      res_ld = W'(CKE_MIN - 1);
    end else begin
      unique case (kind)
        K_SR:    res_ld = W'(RES_SR - 1);
        K_DPD:   res_ld = W'(RES_DPD - 1);
        default: res_ld = W'(CKE_MIN - 1);
      endcase
    end
  end

  assign lock_ld = (cur_mode == LP_SR) ? W'(LOCK_SR) : W'(LOCK_XP);
endmodule

// File: rtl/lp_cke_seq.sv
module lp_cke_seq
  import lp_pkg::*;
#(
  parameter int unsigned NB          = 8,
  parameter int unsigned TCK_PS      = 1875,
  parameter int unsigned CKE_MIN_CYC = 3,
  parameter int unsigned SR_MIN_PS   = 15000,
  parameter int unsigned SR_MIN_CYC  = 3,
  parameter int unsigned XSR_PS      = 140000,
  parameter int unsigned XSR_CYC     = 2,
  parameter int unsigned XP_PS       = 7500,
  parameter int unsigned XP_CYC      = 2,
  parameter int unsigned DPD_MIN_PS  = 500000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ent_valid,
  output logic          ent_ready,
  input  logic [1:0]    ent_kind,
  input  logic [1:0]    sr_span_in,
  input  logic [NB-1:0] bank_open,
  input  logic          ext_valid,
  output logic          ext_ready,
  input  logic          reinit_ack,
  output logic          cke,
  output logic          cmd_ok,
  output logic [2:0]    lp_mode,
  output logic          sr_on,
  output logic [1:0]    sr_span,
  output logic          need_reinit
);
  localparam int unsigned RES_SR  = span_cycles(SR_MIN_PS, TCK_PS,
                                                umax(SR_MIN_CYC, CKE_MIN_CYC));
  localparam int unsigned RES_DPD = span_cycles(DPD_MIN_PS, TCK_PS, CKE_MIN_CYC);
  localparam int unsigned LOCK_SR = span_cycles(XSR_PS, TCK_PS, XSR_CYC);
  localparam int unsigned LOCK_XP = span_cycles(XP_PS, TCK_PS, XP_CYC);
  localparam int unsigned MAXV    = umax(umax(RES_SR, RES_DPD),
                                         umax(umax(LOCK_SR, LOCK_XP), CKE_MIN_CYC));
  localparam int unsigned CW      = $clog2(MAXV + 1);

  lp_mode_e mode_q, mode_d;
  lp_kind_e kind;
  logic     res_zero, lock_zero;
  logic     ent_fire, ext_fire, res_load;
  logic [CW-1:0] res_ld, lock_ld;
  logic [1:0]    span_q;
  logic          reinit_q;

  assign kind      = lp_kind_e'(ent_kind);
  assign ent_ready = (mode_q == LP_ON) && res_zero && lock_zero && !reinit_q;
  assign ext_ready = (mode_q != LP_ON) && res_zero;
  assign ent_fire  = ent_valid && ent_ready;
  assign ext_fire  = ext_valid && ext_ready;
  assign res_load  = ext_fire || (ent_fire && (kind != K_NOP));

  lp_res_pick #(
    .W(CW), .CKE_MIN(CKE_MIN_CYC), .RES_SR(RES_SR), .RES_DPD(RES_DPD),
    .LOCK_XP(LOCK_XP), .LOCK_SR(LOCK_SR)
  ) u_pick (
    .leaving (ext_fire),
    .kind    (kind),
    .cur_mode(mode_q),
    .res_ld  (res_ld),
    .lock_ld (lock_ld)
  );

  // Residency: minimum time in the current CKE level.
  lp_cnt #(.W(CW), .RST_VAL(CKE_MIN_CYC - 1)) u_res (
    .clk(clk), .rst_n(rst_n), .load(res_load), .ld_val(res_ld), .zero(res_zero)
  );

  // Lockout: cycles after CKE rises before a command may go out.
  lp_cnt #(.W(CW), .RST_VAL(0)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(ext_fire), .ld_val(lock_ld), .zero(lock_zero)
  );

  always_comb begin
    mode_d = mode_q;
    if (ext_fire) begin
      mode_d = LP_ON;
    end else if (ent_fire) begin
      unique case (kind)
        K_PD:    mode_d = (|bank_open) ? LP_PD_ACT : LP_PD_IDLE;
        K_SR:    mode_d = LP_SR;
        K_DPD:   mode_d = LP_DPD;
        default: mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= LP_ON;
      span_q   <= 2'b00;
      reinit_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (ent_fire && (kind == K_SR)) span_q <= sr_span_in;
      if (ext_fire && (mode_q == LP_DPD)) reinit_q <= 1'b1;
      else if (reinit_ack)                reinit_q <= 1'b0;
    end
  end

  assign cke         = (mode_q == LP_ON);
  assign cmd_ok      = cke && lock_zero && !reinit_q;
  assign lp_mode     = mode_q;
  assign sr_on       = (mode_q == LP_SR);
  assign sr_span     = span_q;
  assign need_reinit = reinit_q;
endmodule

// File: rtl/lp_cke_seq_chk.sv
module lp_cke_seq_chk #(
  parameter int unsigned CKE_MIN = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cmd_ok,
  input logic       ent_ready,
  input logic       ext_ready,
  input logic       sr_on,
  input logic [1:0] sr_span,
  input logic       need_reinit
);
  logic       cke_q;
  logic [7:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q <= 1'b1;
      run   <= 8'd1;
    end else begin
      cke_q <= cke;
      if (cke != cke_q)    run <= 8'd1;
      else if (run != '1)  run <= run + 8'd1;
    end
  end

  // R2
  cmd_only_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |-> cke);

  // R5
  cke_pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke != cke_q) |-> (run >= 8'(CKE_MIN)));

  // R6
  lock_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !cmd_ok);

  // R7
  sr_span_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_on && $past(sr_on)) |-> $stable(sr_span));

  // R8
  reinit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    need_reinit |-> (!cmd_ok && !ent_ready));

  // R9
  exit_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready |-> !cke);
endmodule

bind lp_cke_seq lp_cke_seq_chk #(.CKE_MIN(CKE_MIN_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cmd_ok     (cmd_ok),
  .ent_ready  (ent_ready),
  .ext_ready  (ext_ready),
  .sr_on      (sr_on),
  .sr_span    (sr_span),
  .need_reinit(need_reinit)
);

// File: tb/lp_cke_seq_tb.sv
module lp_cke_seq_tb;
  localparam int NB   = 2;
  localparam int TCK  = 10000;
  localparam int CMIN = 3;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int cyc(input int ps, input int fl);
    return mx((ps + TCK - 1) / TCK, fl);
  endfunction

  localparam int E_SR   = mx(cyc(45000, 3), CMIN);   // 5
  localparam int E_DPD  = cyc(200000, CMIN);         // 20
  localparam int E_XP   = cyc(7500, 2);              // 2
  localparam int E_XSR  = cyc(140000, 2);            // 14

  logic clk = 0, rst_n = 0;
  logic ent_valid = 0, ext_valid = 0, reinit_ack = 0;
  logic [1:0] ent_kind = 0, sr_span_in = 0;
  logic [NB-1:0] bank_open = 0;
  logic ent_ready, ext_ready, cke, cmd_ok, sr_on, need_reinit;
  logic [2:0] lp_mode;
  logic [1:0] sr_span;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lp_cke_seq #(
    .NB(NB), .TCK_PS(TCK), .CKE_MIN_CYC(CMIN), .SR_MIN_PS(45000),
    .SR_MIN_CYC(3), .XSR_PS(140000), .XSR_CYC(2), .XP_PS(7500),
    .XP_CYC(2), .DPD_MIN_PS(200000)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_kind(ent_kind), .sr_span_in(sr_span_in), .bank_open(bank_open),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .reinit_ack(reinit_ack),
    .cke(cke), .cmd_ok(cmd_ok), .lp_mode(lp_mode), .sr_on(sr_on),
    .sr_span(sr_span), .need_reinit(need_reinit)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int w = 0; w < 300; w++) begin
      if (ent_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic run_one(input int kind, input int banks, input int span,
                         input int exp_mode, input int exp_res, input int exp_lock);
    int low, lock, gap;
    wait_ready();
    ent_valid = 1; ent_kind = 2'(kind); bank_open = NB'(banks); sr_span_in = 2'(span);
    @(negedge clk);
    ent_valid = 0;
    chk("R3 mode code", lp_mode, exp_mode);
    chk("R2 cke low after entry", cke, 0);
    chk("R2 cmd_ok low while cke low", cmd_ok, 0);
    chk("R10 sr_on", sr_on, (kind == 1) ? 1 : 0);
    if (kind == 1) begin
      chk("R7 span latched", sr_span, span);
      sr_span_in = ~2'(span);
    end
    ext_valid = 1;
    low = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (cke) break;
      low++;
    end
    ext_valid = 0;
    chk("R4 low residency", low, exp_res);
    if (kind == 1) chk("R7 span kept after input change", sr_span, span);
    if (kind == 2) begin
      chk("R8 need_reinit set", need_reinit, 1);
      repeat (5) @(negedge clk);
      chk("R8 cmd_ok blocked", cmd_ok, 0);
      chk("R8 entry blocked", ent_ready, 0);
      reinit_ack = 1;
      @(negedge clk);
      reinit_ack = 0;
      chk("R8 need_reinit cleared", need_reinit, 0);
      chk("R8 cmd_ok back", cmd_ok, 1);
    end else begin
      lock = 0; gap = 0;
      for (int i = 0; i < 100; i++) begin
        if (!cmd_ok) lock++;
        if (!ent_ready) gap++;
        if (cmd_ok && ent_ready) break;
        @(negedge clk);
      end
      chk("R6 command lockout", lock, exp_lock);
      chk("R5 entry gap after rise", gap, mx(CMIN - 1, exp_lock));
      chk("R5 cke stays high", cke, 1);
    end
  endtask

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cke", cke, 1);
    chk("R1 cmd_ok", cmd_ok, 1);
    chk("R1 lp_mode", lp_mode, 0);
    chk("R1 sr_on", sr_on, 0);
    chk("R1 need_reinit", need_reinit, 0);
    chk("R1 sr_span", sr_span, 0);

    // Exit request while CKE high is ignored
    ext_valid = 1;
    for (int i = 0; i < 4; i++) begin
      chk("R9 ext_ready low while high", ext_ready, 0);
      @(negedge clk);
    end
    ext_valid = 0;
    chk("R9 cke unaffected", cke, 1);

    // No-op entry is consumed without effect
    wait_ready();
    ent_valid = 1; ent_kind = 2'd3;
    @(negedge clk);
    ent_valid = 0;
    chk("R2 no-op mode", lp_mode, 0);
    chk("R2 no-op cke", cke, 1);
    chk("R2 no-op cmd_ok", cmd_ok, 1);

    for (int b = 0; b < 4; b++) run_one(0, b, 0, (b != 0) ? 2 : 1, CMIN, E_XP);
    for (int s = 0; s < 4; s++) run_one(1, 0, s, 3, E_SR, E_XSR);
    run_one(2, 0, 0, 4, E_DPD, E_XP);

    // Entry held through the self-refresh lockout
    wait_ready();
    ent_valid = 1; ent_kind = 2'd1; sr_span_in = 2'd2;
    @(negedge clk);
    ent_valid = 0; ext_valid = 1;
    for (int i = 0; i < 100; i++) begin
      if (cke) break;
      @(negedge clk);
    end
    ext_valid = 0;
    ent_valid = 1; ent_kind = 2'd0; bank_open = '0;
    hi = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!cke) break;
      hi++;
    end
    ent_valid = 0;
    chk("R9 held entry high time", hi, mx(CMIN, E_XSR + 1));
    chk("R9 held entry taken", lp_mode, 1);
    chk("R10 sr_on low in power-down", sr_on, 0);
    ext_valid = 1;
    for (int i = 0; i < 100; i++) begin
      if (cke) break;
      @(negedge clk);
    end
    ext_valid = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule